// File: doc/BRIEF.md
# Reloadable Timer Baud Rate Generator

This block turns the peripheral clock into a periodic baud tick for a serial port. An up-counter runs until it wraps from its all-ones value. On each wrap it reloads itself from a programmable reload register. Each wrap is one overflow event. The tick rate therefore depends on the reload value. With the default 8-bit counter, one period lasts 256 minus the reload value counter steps.

Two control inputs change the rate by fixed factors:

- **Speed select** chooses the counter step. The counter can advance on every clock cycle, or only once per prescaler cycle of six clocks.
- **Doubling select** chooses whether overflows pass through a divide-by-2 stage. Bypassing that stage doubles the baud rate.

A run enable starts and freezes the whole chain. The tick output is a single-cycle pulse that a serial port samples as its bit-rate strobe.

Top module: `brg_top`

## Requirements
- R1: After reset the tick is low and the counter, reload register, prescaler and halving stage are all zero. With fast step and doubling selected, the first tick is seen 256 cycles after the run enable is raised.
- R2: The counter counts up. On the step that wraps it from 255, it loads the reload register. With fast step and doubling selected, ticks repeat every 256 - reload cycles.
- R3: With speed select low, the counter advances once every six cycles. The tick period is then six times the fast-step period.
- R4: With doubling select low, only every second overflow produces a tick, so the period doubles. After reset, the first tick comes on the second overflow.
- R5: The tick is high for exactly one clock cycle per overflow event that reaches the output. With reload 255, fast step and doubling selected, every cycle is an overflow, so the tick stays high on consecutive cycles.
- R6: While run enable is low, the counter, prescaler and halving stage hold, and no tick is produced. On re-enable, the time to the next tick is the time that remained when the block was stopped.
- R7: A reload write does not disturb the count in progress. The new value is first used at the next wrap.
- R8: The reload register is loaded from the reload data input only in a cycle where the reload write strobe is high. A change of reload data without the strobe does not alter the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Run enable; low freezes the generator |
| fastSel | input | 1 | 1: counter steps every cycle; 0: every sixth cycle |
| dblSel | input | 1 | 1: every overflow ticks; 0: every second overflow ticks |
| reloadWr | input | 1 | Write strobe for the reload register |
| reloadData | input | 8 | Value written to the reload register |
| baudTick | output | 1 | One-cycle baud strobe |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and a divide-by-six prescaler. With these values a full period in every mode stays under 3100 cycles, so the bench measures exact tick intervals in all four speed and doubling combinations. It also checks the extreme reload values 0 and 255, where the period is longest and where the tick becomes continuous. Freezing the block partway through a prescaler cycle and partway through a count shows that both resume exactly where they stopped.

// File: rtl/brg_pkg.sv
package brg_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic cntAdv;   // counter takes one step this cycle
    logic passAll;  // halving stage bypassed
  } brgStrobe_t;
endpackage

// File: rtl/brg_ctrl.sv
module brg_ctrl
  import brg_pkg::*;
#(
  parameter int PRE_DIV = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             runEn,
  input  logic             fastSel,
  input  logic             dblSel,
  output brgStrobe_t       strobe,
  output logic [7:0]       preCntOut
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic preHit;

  generate
    if (PRE_DIV > 1) begin : g_pre
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          preCnt <= '0;
        end else if (runEn && !fastSel) begin
          preCnt <= (preCnt == PRE_LAST) ? '0 : preCnt + 1'b1;
        end
      end
      assign preHit    = (preCnt == PRE_LAST);
      assign preCntOut = 8'(preCnt);
    end else begin : g_nopre
      assign preHit    = 1'b1;
      assign preCntOut = 8'd0;
    end
  endgenerate

  always_comb begin
    strobe.cntAdv  = runEn && (fastSel || preHit);
    strobe.passAll = dblSel;
  end
endmodule

// File: rtl/brg_datapath.sv
module brg_datapath
  import brg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  brgStrobe_t       strobe,
  input  logic             reloadWr,
  input  logic [CNT_W-1:0] reloadData,
  output logic             baudTick,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] reloadQ,
  output logic             ovfEvt,
  output logic             halfQ
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic tickNext;

  assign ovfEvt   = strobe.cntAdv && (cntQ == CNT_MAX);
  assign tickNext = ovfEvt && (strobe.passAll || halfQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reloadQ <= '0;
    end else if (reloadWr) begin
      reloadQ <= reloadData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntQ <= '0;
    end else if (strobe.cntAdv) begin
      cntQ <= (cntQ == CNT_MAX) ? reloadQ : cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halfQ <= 1'b0;
    end else if (ovfEvt && !strobe.passAll) begin
      halfQ <= !halfQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) baudTick <= 1'b0;
    else        baudTick <= tickNext;
  end
endmodule

// File: rtl/brg_top.sv
module brg_top
  import brg_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int PRE_DIV = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             runEn,
  input  logic             fastSel,
  input  logic             dblSel,
  input  logic             reloadWr,
  input  logic [CNT_W-1:0] reloadData,
  output logic             baudTick
);
  brgStrobe_t       strobe;
  logic [7:0]       preCnt;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] reloadQ;
  logic             ovfEvt;
  logic             halfQ;

  brg_ctrl #(.PRE_DIV(PRE_DIV)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .runEn(runEn), .fastSel(fastSel),
    .dblSel(dblSel), .strobe(strobe), .preCntOut(preCnt)
  );

  brg_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .reloadWr(reloadWr),
    .reloadData(reloadData), .baudTick(baudTick), .cntQ(cntQ),
    .reloadQ(reloadQ), .ovfEvt(ovfEvt), .halfQ(halfQ)
  );
endmodule

// File: rtl/brg_chk.sv
module brg_chk #(
  parameter int CNT_W   = 8,
  parameter int PRE_DIV = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             runEn,
  input logic             fastSel,
  input logic             reloadWr,
  input logic             baudTick,
  input logic [CNT_W-1:0] cntQ,
  input logic [CNT_W-1:0] reloadQ,
  input logic             ovfEvt,
  input logic             halfQ,
  input logic [7:0]       preCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R2
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovfEvt && !reloadWr |=> cntQ == $past(reloadQ));

  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    runEn && fastSel && cntQ != CNT_MAX |=> cntQ == $past(cntQ) + 1'b1);

  // R3
  slow_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    runEn && !fastSel && preCnt != 8'(PRE_DIV - 1) |=> $stable(cntQ));

  // R5
  tick_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baudTick |-> $past(ovfEvt));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !runEn |=> !baudTick && $stable(cntQ) && $stable(preCnt) && $stable(halfQ));
endmodule

bind brg_top brg_chk #(.CNT_W(CNT_W), .PRE_DIV(PRE_DIV)) chk_i (
  .clk(clk), .rst_n(rst_n), .runEn(runEn), .fastSel(fastSel),
  .reloadWr(reloadWr), .baudTick(baudTick), .cntQ(cntQ),
  .reloadQ(reloadQ), .ovfEvt(ovfEvt), .halfQ(halfQ), .preCnt(preCnt)
);

// File: tb/brg_top_tb_top.sv
module brg_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       runEn = 1'b0;
  logic       fastSel = 1'b0;
  logic       dblSel = 1'b0;
  logic       reloadWr = 1'b0;
  logic [7:0] reloadData = 8'd0;
  logic       baudTick;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brg_top dut_i (
    .clk(clk), .rst_n(rst_n), .runEn(runEn), .fastSel(fastSel),
    .dblSel(dblSel), .reloadWr(reloadWr), .reloadData(reloadData),
    .baudTick(baudTick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; runEn = 1'b0; fastSel = 1'b0; dblSel = 1'b0;
    reloadWr = 1'b0; reloadData = 8'd0;
    repeat (3) @(negedge clk);
    check(baudTick == 1'b0, "R1 reset tick", int'(baudTick), 0);
    rst_n = 1'b1;
  endtask

  task automatic writeReload(input logic [7:0] val);
    reloadData = val; reloadWr = 1'b1;
    @(negedge clk);
    reloadWr = 1'b0;
  endtask

  task automatic waitTick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!baudTick && n < 5000);
  endtask

  task automatic startRun(input bit fast, input bit dbl, input logic [7:0] rl);
    doReset();
    fastSel = fast; dblSel = dbl;
    writeReload(rl);
    runEn = 1'b1;
  endtask

  // R6 idle: no tick while disabled
  task automatic testIdle();
    int seen = 0;
    doReset();
    fastSel = 1'b1; dblSel = 1'b1;
    repeat (300) begin
      @(negedge clk);
      if (baudTick) seen++;
    end
    check(seen == 0, "R6 idle ticks", seen, 0);
  endtask

  // R1, R2, R5 with reload 0
  task automatic testFirst();
    int n;
    doReset();
    fastSel = 1'b1; dblSel = 1'b1; runEn = 1'b1;
    waitTick(n);
    check(n == 256, "R1 first tick", n, 256);
    @(negedge clk);
    check(baudTick == 1'b0, "R5 pulse width", int'(baudTick), 0);
    waitTick(n);
    check(n == 255, "R2 period reload0 rest", n, 255);
  endtask

  // R2/R3/R4 period measurement
  task automatic testPeriod(input bit fast, input bit dbl, input logic [7:0] rl, input string req);
    int n, exp;
    exp = (256 - int'(rl)) * (fast ? 1 : 6) * (dbl ? 1 : 2);
    startRun(fast, dbl, rl);
    waitTick(n);
    waitTick(n);
    check(n == exp, req, n, exp);
    waitTick(n);
    check(n == exp, req, n, exp);
  endtask

  // R4 first tick after second overflow
  task automatic testFirstHalved();
    int n;
    startRun(1'b1, 1'b0, 8'd200);
    waitTick(n);
    check(n == 312, "R4 first halved tick", n, 312);
  endtask

  // R5 continuous tick at reload 255
  task automatic testMaxReload();
    int n, highs = 0;
    startRun(1'b1, 1'b1, 8'd255);
    waitTick(n);
    repeat (5) begin
      @(negedge clk);
      if (baudTick) highs++;
    end
    check(highs == 5, "R5 reload255 continuous", highs, 5);
  endtask

  // R6 freeze and resume
  task automatic testHold(input bit fast, input logic [7:0] rl, input int pre, input int expRest);
    int n, seen = 0;
    startRun(fast, 1'b1, rl);
    waitTick(n);
    repeat (pre) @(negedge clk);
    runEn = 1'b0;
    @(negedge clk);
    repeat (40) begin
      @(negedge clk);
      if (baudTick) seen++;
    end
    check(seen == 0, "R6 frozen ticks", seen, 0);
    runEn = 1'b1;
    waitTick(n);
    check(n == expRest, "R6 resume remainder", n, expRest);
  endtask

  // R7 reload write mid-count, R8 data without strobe
  task automatic testReloadWrite();
    int n;
    startRun(1'b1, 1'b1, 8'd200);
    waitTick(n);
    repeat (9) @(negedge clk);
    writeReload(8'd100);
    n = 10;
    while (!baudTick && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(n == 56, "R7 current period kept", n, 56);
    reloadData = 8'd10;
    waitTick(n);
    check(n == 156, "R7 new reload used", n, 156);
    waitTick(n);
    check(n == 156, "R8 data without strobe ignored", n, 156);
  endtask

  initial begin
    testIdle();
    testFirst();
    testPeriod(1'b1, 1'b1, 8'd100, "R2 fast doubled period");
    testPeriod(1'b0, 1'b1, 8'd200, "R3 slow doubled period");
    testPeriod(1'b1, 1'b0, 8'd200, "R4 fast halved period");
    testPeriod(1'b0, 1'b0, 8'd240, "R3 R4 slow halved period");
    testFirstHalved();
    testMaxReload();
    testHold(1'b1, 8'd200, 20, 36);
    testHold(1'b0, 8'd250, 15, 21);
    testReloadWrite();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule